// File: doc/BRIEF.md
# Priority Interrupt Vector Generator

This block gathers a word of interrupt request lines into a sticky raw status register. Each line is gated with a per-line enable, and each line is sorted into a critical or a non-critical class. Two level outputs tell the processor whether any enabled interrupt of each class is pending. For critical interrupts only, the block also forms a handler address. It finds the highest-priority pending enabled critical line and adds that line's priority rank, times a fixed 512-byte stride, to a word-aligned base address.

Software reaches the block through a small single-cycle register port. It can read the raw status and clear it one bit at a time, program the enable and class masks, read the masked status, and read the generated vector and its valid flag. A write-only configuration register holds the 30-bit base address and a direction bit. The direction bit chooses which end of the status word has top priority. The generated vector can serve as an index into a table of handler addresses. It can also point straight at handlers laid out at 512-byte spacing.

Status numbering is big-endian: status number s sits at data bit N_SRC-1-s, so status 0 is the most significant bit. External request lines 0 to 6 therefore occupy status numbers 25 to 31, which are data bits 6 down to 0. The request input uses the same bit layout as the status word.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, every register reads 0, the vector (address 5) reads 0, the valid flag (address 6 bit 0) reads 0, and both interrupt outputs are low.
- R2: The raw status register (address 0) sets a bit in the cycle after the matching `irq_req` bit is 1. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If a set and a clear reach the same bit in the same cycle, the set wins.
- R3: The enable mask (address 1) and the class mask (address 2, where 1 means critical) read back what was written. Address 3 reads raw AND enable, and writes to address 3 change nothing.
- R4: The configuration register (address 4) takes the base address from data bits 31:2 and the direction from bit 0. Reading address 4 always returns 0.
- R5: With direction 0, status 0 (data bit 31) has top priority, and the rank equals the status number. With direction 1, status 31 (data bit 0) has top priority, and the rank equals 31 minus the status number.
- R6: When an enabled critical interrupt is pending, address 5 reads {base,2'b00} + rank*512, modulo 2^32. This value follows the current direction and masks with no clock delay.
- R7: Pending non-critical interrupts never change the vector. When no enabled critical interrupt is pending, address 5 reads {base,2'b00} and the valid flag reads 0. Otherwise the valid flag reads 1.
- R8: `crit_irq` is high exactly when an enabled critical interrupt is pending. `noncrit_irq` is high exactly when an enabled non-critical interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_SRC | Request lines, with status s at bit N_SRC-1-s |
| reg_addr | input | ADDR_W | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| crit_irq | output | 1 | Enabled critical interrupt pending |
| noncrit_irq | output | 1 | Enabled non-critical interrupt pending |

## Verification
The bench builds the block with its defaults: 32 sources, a 32-bit data path and a 512-byte stride. With these values both end positions of the status word are reachable, so the top-priority line can be checked under each direction. Ranks up to 31 are exercised, and all-ones base addresses push the vector sum past 2^32, so wrap-around is tested. Random masks and sparse random requests mix critical and non-critical lines, which tests that non-critical lines are kept out of the vector.

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int N_SRC       = 32,
  parameter int DATA_W      = 32,
  parameter int STRIDE_LOG2 = 9,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              crit_irq,
  output logic              noncrit_irq
);
  localparam int RANK_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int BASE_W = DATA_W - 2;

  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_VLD  = ADDR_W'(6);

  logic [N_SRC-1:0]  raw_q, en_q, cls_q;
  logic [BASE_W-1:0] base_q;
  logic              dir_q;

  logic [N_SRC-1:0]  masked, crit_m, ncrit_m;
  logic [RANK_W-1:0] rank;
  logic              hit;
  logic [DATA_W-1:0] base_addr, vector;

  wire wr_raw = reg_we && (reg_addr == A_RAW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q  <= '0;
      en_q   <= '0;
      cls_q  <= '0;
      base_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~(wr_raw ? reg_wdata[N_SRC-1:0] : '0)) | irq_req;
      if (reg_we && reg_addr == A_EN)  en_q  <= reg_wdata[N_SRC-1:0];
      if (reg_we && reg_addr == A_CLS) cls_q <= reg_wdata[N_SRC-1:0];
      if (reg_we && reg_addr == A_CFG) begin
        base_q <= reg_wdata[DATA_W-1:2];
        dir_q  <= reg_wdata[0];
      end
    end
  end

  assign masked  = raw_q & en_q;
  assign crit_m  = masked & cls_q;
  assign ncrit_m = masked & ~cls_q;

  always_comb begin
    hit  = 1'b0;
    rank = '0;
    for (int r = 0; r < N_SRC; r++) begin
      if (!hit && crit_m[dir_q ? r : N_SRC-1-r]) begin
        hit  = 1'b1;
        rank = RANK_W'(r);
      end
    end
  end

  assign base_addr = {base_q, 2'b00};
  assign vector    = hit ? base_addr + (DATA_W'(rank) << STRIDE_LOG2) : base_addr;

  assign crit_irq    = |crit_m;
  assign noncrit_irq = |ncrit_m;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RAW: reg_rdata = DATA_W'(raw_q);
      A_EN:  reg_rdata = DATA_W'(en_q);
      A_CLS: reg_rdata = DATA_W'(cls_q);
      A_MSK: reg_rdata = DATA_W'(masked);
      A_VEC: reg_rdata = vector;
      A_VLD: reg_rdata = DATA_W'(hit);
      default: reg_rdata = '0;
    endcase
  end

  AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |=> ((raw_q & $past(irq_req)) == $past(irq_req))); // R2
  AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_raw |=> ((raw_q & $past(reg_wdata[N_SRC-1:0] & ~irq_req)) == '0)); // R2
  AST_CFG_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CFG) |-> (reg_rdata == '0)); // R4
  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_irq |-> (vector == base_addr && !hit)); // R7
  AST_CRIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    crit_irq |-> hit); // R8
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_VEC) |-> (reg_rdata[1:0] == 2'b00)); // R6
endmodule

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_req = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        crit_irq, noncrit_irq;

  int tests = 0;
  int fails = 0;

  logic [31:0] m_raw, m_en, m_cls;
  logic [29:0] m_base;
  logic        m_dir;

  always #10 clk = ~clk;

  irq_vector_unit u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .crit_irq(crit_irq), .noncrit_irq(noncrit_irq)
  );

  function automatic logic [32:0] ref_vec();
    logic [31:0] cm;
    cm = m_raw & m_en & m_cls;
    for (int r = 0; r < 32; r++) begin
      if (cm[m_dir ? r : 31 - r]) return {1'b1, {m_base, 2'b00} + 32'(r * 512)};
    end
    return {1'b0, m_base, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] req, input logic we, input logic [2:0] a, input logic [31:0] d);
    irq_req = req; reg_we = we; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (we) begin
      case (a)
        3'd0: m_raw = m_raw & ~d;
        3'd1: m_en  = d;
        3'd2: m_cls = d;
        3'd4: begin m_base = d[31:2]; m_dir = d[0]; end
        default: ;
      endcase
    end
    m_raw = m_raw | req;
    @(negedge clk);
    irq_req = '0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    logic [32:0] e;
    e = ref_vec();
    rd(3'd0, v); chk("R2 raw", v, m_raw);
    rd(3'd1, v); chk("R3 enable", v, m_en);
    rd(3'd2, v); chk("R3 class", v, m_cls);
    rd(3'd3, v); chk("R3 masked", v, m_raw & m_en);
    rd(3'd4, v); chk("R4 cfg reads zero", v, 32'h0);
    rd(3'd5, v); chk("R6 vector", v, e[31:0]);
    rd(3'd6, v); chk("R7 valid", v, {31'h0, e[32]});
    chk("R8 crit_irq", {31'h0, crit_irq}, {31'h0, |(m_raw & m_en & m_cls)});
    chk("R8 noncrit_irq", {31'h0, noncrit_irq}, {31'h0, |(m_raw & m_en & ~m_cls)});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    m_raw = '0; m_en = '0; m_cls = '0; m_base = '0; m_dir = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd5, v); chk("R1 vector after reset", v, 32'h0);
    rd(3'd6, v); chk("R1 valid after reset", v, 32'h0);
    chk("R1 outputs low", {30'h0, crit_irq, noncrit_irq}, 32'h0);
    check_all();

    // R2 set wins over clear in the same cycle, write 0 leaves bits
    cyc(32'hF000_000F, 1'b0, 3'd0, 32'h0);
    cyc(32'h1000_0000, 1'b1, 3'd0, 32'h3000_0001);
    check_all();
    cyc(32'h0, 1'b1, 3'd0, 32'h0);
    check_all();

    // R3 writes to masked status are ignored
    cyc(32'h0, 1'b1, 3'd1, 32'hFFFF_FFFF);
    cyc(32'h0, 1'b1, 3'd3, 32'h0);
    check_all();

    // R7 only non-critical pending: vector is base, valid 0
    cyc(32'h0, 1'b1, 3'd4, 32'hABCD_0000);
    check_all();
    rd(3'd5, v); chk("R7 noncrit leaves vector at base", v, 32'hABCD_0000);

    // R5 end positions under both directions
    cyc(32'h0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    cyc(32'h0, 1'b1, 3'd2, 32'hFFFF_FFFF);
    cyc(32'h8000_0001, 1'b0, 3'd0, 32'h0);
    rd(3'd5, v); chk("R5 dir0 status0 wins rank0", v, 32'hABCD_0000);
    cyc(32'h0, 1'b1, 3'd4, 32'hABCD_0001);
    rd(3'd5, v); chk("R5 dir1 status31 wins rank0", v, 32'hABCD_0000);
    cyc(32'h0, 1'b1, 3'd0, 32'h0000_0001);
    rd(3'd5, v); chk("R5 dir1 status0 rank31", v, 32'hABCD_0000 + 32'd31 * 512);
    cyc(32'h0, 1'b1, 3'd4, 32'hABCD_0000);
    rd(3'd5, v); chk("R6 dir flip seen at next read", v, 32'hABCD_0000);
    // R6 wrap with all-ones base
    cyc(32'h0, 1'b1, 3'd0, 32'hFFFF_FFFF);
    cyc(32'h0000_0001, 1'b1, 3'd4, 32'hFFFF_FFFC);
    rd(3'd5, v); chk("R6 vector wraps", v, 32'hFFFF_FFFC + 32'd31 * 512);
    check_all();
    // R6 masking a line changes the vector without delay beyond the write
    cyc(32'h0, 1'b1, 3'd2, 32'h0);
    rd(3'd6, v); chk("R7 valid drops when class cleared", v, 32'h0);
    check_all();

    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      logic [2:0]  a;
      d = $urandom;
      a = 3'($urandom_range(0, 6));
      if (a == 3'd0) d = d & $urandom;
      cyc($urandom & $urandom & $urandom, ($urandom_range(0, 3) != 0), a, d);
      check_all();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule